// File: doc/BRIEF.md
# Round-Robin Tagged Byte Merger

This block drains a set of byte-wide receive FIFOs into one shared output queue. A rotating pointer visits one source per clock. When the visited source holds data and the output queue has room, the merger pulses that source's read request. The byte appears on the source's data lane in the next cycle, as a FIFO without look-ahead presents it. The merger registers it, together with the number of the source it came from, into a 12-bit word and pulses the output write strobe once.

Because every output word carries its source number, a consumer on the far side of the single queue can still sort the bytes back per channel. The number of sources is a parameter from 1 to 16. When that number is not a power of two, the pointer wraps at the last real source. A full output queue freezes the pointer and stops new reads. Bytes already requested still reach the output, so the output FIFO must raise its full flag while it still has two free entries.

Top module: `tagged_rr_merger`

## Requirements
- R1: The pointer starts at source 0, moves to the next source on every clock in which `out_full` is low, and goes from source N_SRC-1 back to 0 even when N_SRC is not a power of two.
- R2: While `rst_n` is low, asynchronously and at once, the pointer returns to 0, `src_rd` is all zero, `out_wr` is 0 and `out_word` is 0.
- R3: In a cycle where `out_full` is low and the visited source's `src_empty` bit is 0, exactly that source's `src_rd` bit is 1. If the visited source is empty, no `src_rd` bit is set.
- R4: Each read request produces exactly one `out_wr` pulse, one cycle long, two cycles after the request cycle. Words leave in request order.
- R5: `out_word[7:0]` is the byte the source presented in the cycle after its request, and `out_word[11:8]` is that source's index.
- R6: While `out_full` is high, no `src_rd` bit is set and the pointer keeps its value. A byte requested before `out_full` rose is still written.
- R7: Source i drives its byte on `src_data[8*i+7:8*i]`, its empty flag on `src_empty[i]`, and takes its read request on `src_rd[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_data | input | 8*N_SRC | Byte lanes of the sources, source i in bits 8i+7:8i |
| src_empty | input | N_SRC | Empty flag per source |
| src_rd | output | N_SRC | Single-cycle read request per source |
| out_full | input | 1 | Output queue cannot accept new reads |
| out_wr | output | 1 | Write strobe to the output queue |
| out_word | output | 12 | Source index in 11:8, data byte in 7:0 |

## Verification
Two things can happen in the same cycle: a new read request to the visited source, and the write of a word requested two cycles earlier. The same holds for a rise of `out_full` and a word still in flight. The bench provokes both overlaps. It keeps every source loaded while `out_full` follows a pseudo-random sequence, so requests, stalls and writes fall on top of one another. A reference pointer and a queue of expected words judge every cycle: the `src_rd` pattern is compared, and each `out_wr` pulse is matched against the oldest outstanding request. A reset in the middle of traffic checks that words in flight are dropped and that the visits restart at source 0.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  localparam int BYTE_W = 8;
  localparam int TAG_W  = 4;
  localparam int WORD_W = BYTE_W + TAG_W;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  // next source after cur, wrapping after last
  function automatic tag_t next_idx(input tag_t cur, input tag_t last);
    return (cur == last) ? tag_t'(0) : tag_t'(cur + tag_t'(1));
  endfunction

  // output word: tag above the byte
  function automatic word_t pack_word(input tag_t tag, input byte_t b);
    return {tag, b};
  endfunction
endpackage

// File: rtl/rrm_pointer.sv
module rrm_pointer
  import rrm_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall,
  output tag_t ptr
);
  localparam tag_t LAST = tag_t'(N_SRC - 1);

  tag_t ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (!stall) ptr_q <= next_idx(ptr_q, LAST);
  end

  assign ptr = ptr_q;

  // R1
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);
  // R1
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> ptr_q == next_idx($past(ptr_q), LAST));
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(ptr_q));
endmodule

// File: rtl/rrm_request.sv
module rrm_request
  import rrm_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tag_t             ptr,
  input  logic [N_SRC-1:0] src_empty,
  input  logic             out_full,
  output logic             fire,
  output logic [N_SRC-1:0] src_rd
);
  logic cur_empty;

  always_comb begin
    cur_empty = 1'b1;
    for (int i = 0; i < N_SRC; i++)
      if (ptr == tag_t'(i)) cur_empty = src_empty[i];
  end

  assign fire = rst_n && !out_full && !cur_empty;

  always_comb begin
    src_rd = '0;
    for (int i = 0; i < N_SRC; i++)
      src_rd[i] = fire && (ptr == tag_t'(i));
  end

  // R3
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_rd));
  // R3
  rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd & src_empty) == '0);
  // R6
  rd_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_full |-> src_rd == '0);
endmodule

// File: rtl/rrm_capture.sv
module rrm_capture
  import rrm_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  tag_t                    ptr,
  input  logic [BYTE_W*N_SRC-1:0] src_data,
  output logic                    pend_v,
  output logic                    out_wr,
  output word_t                   out_word
);
  tag_t  pend_tag;
  byte_t lane [N_SRC];
  byte_t pick;

  for (genvar g = 0; g < N_SRC; g++) begin : g_lane
    assign lane[g] = src_data[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < N_SRC; i++)
      if (pend_tag == tag_t'(i)) pick = lane[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_tag <= '0;
      out_wr   <= 1'b0;
      out_word <= '0;
    end else begin
      pend_v   <= fire;
      pend_tag <= ptr;
      out_wr   <= pend_v;
      if (pend_v) out_word <= pack_word(pend_tag, pick);
    end
  end

  // R4
  fire_to_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pend_v);
  // R4
  pend_to_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |=> out_wr);
  // R4
  wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_wr) |-> $past(pend_v));
  // R5
  tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> out_word[WORD_W-1:BYTE_W] <= tag_t'(N_SRC - 1));
endmodule

// File: rtl/tagged_rr_merger.sv
module tagged_rr_merger
  import rrm_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [8*N_SRC-1:0]     src_data,
  input  logic [N_SRC-1:0]       src_empty,
  output logic [N_SRC-1:0]       src_rd,
  input  logic                   out_full,
  output logic                   out_wr,
  output logic [11:0]            out_word
);
  tag_t  ptr;
  logic  fire;
  logic  pend_v;
  word_t word_q;

  rrm_pointer #(.N_SRC(N_SRC)) u_ptr (
    .clk(clk), .rst_n(rst_n), .stall(out_full), .ptr(ptr)
  );

  rrm_request #(.N_SRC(N_SRC)) u_req (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .src_empty(src_empty),
    .out_full(out_full), .fire(fire), .src_rd(src_rd)
  );

  rrm_capture #(.N_SRC(N_SRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ptr(ptr),
    .src_data(src_data), .pend_v(pend_v), .out_wr(out_wr),
    .out_word(word_q)
  );

  assign out_word = word_q;

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_wr && src_rd == '0 && out_word == '0));
endmodule

// File: tb/tagged_rr_merger_bench.sv
module tagged_rr_merger_bench;
  localparam int N = 5;
  localparam int D = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [8*N-1:0] src_data;
  logic [N-1:0]   src_empty;
  logic [N-1:0]   src_rd;
  logic           out_full = 1'b0;
  logic           out_wr;
  logic [11:0]    out_word;

  always #10 clk = ~clk;

  tagged_rr_merger #(.N_SRC(N)) u_tagged_rr_merger (
    .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_empty(src_empty),
    .src_rd(src_rd), .out_full(out_full), .out_wr(out_wr), .out_word(out_word)
  );

  // source FIFO models, no look-ahead (R7 lanes)
  logic [7:0] mem [N][D];
  logic [7:0] q   [N];
  int rp [N];
  int wp [N];

  initial for (int s = 0; s < N; s++) begin rp[s] = 0; wp[s] = 0; q[s] = 8'h00; end

  always_comb for (int s = 0; s < N; s++) begin
    src_data[s*8 +: 8] = q[s];
    src_empty[s]       = (rp[s] == wp[s]);
  end

  always @(posedge clk)
    for (int s = 0; s < N; s++)
      if (src_rd[s]) begin
        q[s]  <= mem[s][rp[s] % D];
        rp[s] <= rp[s] + 1;
      end

  int checks = 0;
  int fails  = 0;
  logic [11:0] exp_q [$];
  int ref_ptr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference and scoreboard monitor
  always @(negedge clk) begin
    logic [N-1:0] exp_rd;
    logic [11:0]  w;
    if (!rst_n) begin
      exp_q.delete();
      ref_ptr = 0;
      chk(!out_wr && out_word == 12'h0 && src_rd == '0, "R2",
          {out_wr, src_rd, out_word}, 32'h0);
    end else begin
      if (out_wr) begin
        if (exp_q.size() == 0) chk(1'b0, "R4", out_word, 32'hFFF);
        else begin
          w = exp_q.pop_front();
          chk(out_word == w, "R5", out_word, w);
        end
      end
      exp_rd = '0;
      if (!out_full && rp[ref_ptr] != wp[ref_ptr]) exp_rd[ref_ptr] = 1'b1;
      chk(src_rd == exp_rd, out_full ? "R6" : "R3", src_rd, exp_rd);
      if (exp_rd != '0) exp_q.push_back({4'(ref_ptr), mem[ref_ptr][rp[ref_ptr] % D]});
      if (!out_full) ref_ptr = (ref_ptr == N-1) ? 0 : ref_ptr + 1; // R1
    end
  end

  task automatic load(input int s, input int n, input logic [7:0] base);
    for (int k = 0; k < n; k++) begin
      mem[s][wp[s] % D] = base + 8'(k);
      wp[s] = wp[s] + 1;
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic drain(input string req);
    int lim = 0;
    bit busy = 1'b1;
    repeat (3) step();
    while (busy && lim < 300) begin
      busy = (exp_q.size() != 0) || out_wr;
      for (int s = 0; s < N; s++) if (rp[s] != wp[s]) busy = 1'b1;
      step();
      lim++;
    end
    chk(!busy, req, exp_q.size(), 0);
  endtask

  initial begin
    logic [7:0] lf = 8'hA5;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R3 R5: all sources busy, interleaved by index
    for (int s = 0; s < N; s++) load(s, 3, 8'(s * 16 + 8'h10));
    drain("R3");
    // R1: sparse sources, last index wraps to 0
    load(2, 4, 8'hA0);
    load(4, 4, 8'hC0);
    drain("R1");
    // R6: full holds the pointer and blocks reads
    out_full = 1'b1;
    for (int s = 0; s < N; s++) load(s, 2, 8'(s * 16 + 8'h80));
    repeat (10) step();
    out_full = 1'b0;
    drain("R6");
    // R4: full toggling over continuous traffic
    for (int s = 0; s < N; s++) load(s, 6, 8'(s * 32 + 8'h05));
    for (int c = 0; c < 60; c++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_full = lf[0];
      step();
    end
    out_full = 1'b0;
    drain("R4");
    // R2: reset mid-traffic, visits restart at source 0
    for (int s = 0; s < N; s++) load(s, 4, 8'(s * 8 + 8'h40));
    repeat (4) step();
    rst_n = 1'b0;
    #1;
    chk(!out_wr && src_rd == '0 && out_word == 12'h0, "R2",
        {out_wr, src_rd, out_word}, 32'h0);
    repeat (2) step();
    rst_n = 1'b1;
    drain("R2");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule